// File: doc/BRIEF.md
# External Interrupt Trigger-Mode Detector

This block sits in front of an interrupt group controller. It turns raw activity on eight external interrupt lines into per-line request-set strobes. Each line has its own 2-bit trigger mode. The two edge modes treat any change of the line as an event, whatever the configured direction. The two level modes treat a high line as asserted and a low line as idle, whatever the configured polarity. The block does not store, clear or prioritise requests. The downstream controller does that and ORs each strobe into its request bit for the matching group.

Each line first passes through a two-flop synchronizer. A small per-line state machine then tracks the last synchronized value. It has two states, `LINE_QUIET` (the line was last seen low) and `LINE_ACTIVE` (the line was last seen high). It takes the transition `RISE` from quiet to active when the synchronized input is 1, and `FALL` from active to quiet when it is 0. It otherwise stays where it is (`HOLD`).

In an edge mode, the strobe is raised for one clock whenever the synchronized value differs from the tracked state. In a level mode, the strobe follows the synchronized value. The state machine advances in every mode, so a mode change finds it already up to date.

Software programs the modes through two byte-wide registers. Writes take effect at the clock edge. Reads are combinational on the address.

Top module: `xtrig_detect`

## Requirements
- R1: After reset, both register offsets read 0xAA, so every line is in falling-edge mode (encoding 10), and `req_set` is all zero.
- R2: Offset 0 holds the modes of lines 0–3 and offset 1 holds lines 4–7. Line n's field sits at bits [2(n mod 4)+1 : 2(n mod 4)] of its byte. The encodings are 00 low level, 01 high level, 10 falling edge and 11 rising edge. A written byte reads back unchanged.
- R3: In either edge mode (10 or 11), a rise and a fall of the line each produce a `req_set` strobe of exactly one clock.
- R4: In either level mode (00 or 01), `req_set` for the line is high in every cycle the synchronized line is 1 and low while it is 0.
- R5: A line change sampled at clock edge k shows on `req_set` after edge k+1. This is two register stages.
- R6: Changing a line's mode raises no strobe by itself. After a switch from level to edge mode with the line held high, `req_set` is 0 from the write edge on.
- R7: A write to one offset leaves the other offset's fields unchanged. Without a write, no field changes.
- R8: Lines are independent. An event on one line raises only that line's bit of `req_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 8 | Raw external interrupt lines, asynchronous |
| reg_wr_en | input | 1 | Register write strobe, sampled at the clock edge |
| reg_addr | input | 1 | Register offset (0: lines 0–3, 1: lines 4–7) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| req_set | output | 8 | Per-line request-set strobes for the group controller |

## Verification
A configuration write and the detector's own decision can land in the same clock. The new mode then governs the strobe in the very cycle after the write edge, while the state machine keeps advancing on the unchanged line.

The bench provokes this in two steps. It holds a line high in low-level mode, so the strobe is on every cycle. It then rewrites that field to falling-edge mode. The run is judged correct if the strobe drops right after the write edge and stays low, with no false edge event. A later real transition on the same line must still give exactly one strobe.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;

    // Per-line trigger mode; bit 1 selects edge versus level.
    typedef enum logic [1:0] {
        MODE_LVL_LO    = 2'b00,
        MODE_LVL_HI    = 2'b01,
        MODE_EDGE_FALL = 2'b10,
        MODE_EDGE_RISE = 2'b11
    } trig_mode_e;

    localparam int MODE_W          = 2;
    localparam int REG_W           = 8;
    localparam int FIELDS_PER_REG  = REG_W / MODE_W;
    localparam logic [MODE_W-1:0] MODE_RESET = MODE_EDGE_FALL;

    // Line history state: the last synchronized value observed.
    typedef enum logic {
        LINE_QUIET  = 1'b0,
        LINE_ACTIVE = 1'b1
    } line_state_e;

endpackage

// File: rtl/xtrig_sync.sv
module xtrig_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_in[i];
                stab_q <= meta_q;
            end
        end
        assign sync_out[i] = stab_q;
    end

endmodule

// File: rtl/xtrig_cfg.sv
module xtrig_cfg
    import xtrig_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int ADDR_W    = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [REG_W-1:0]            wdata,
    output logic [REG_W-1:0]            rdata,
    output logic [NUM_LINES*MODE_W-1:0] mode_vec
);

    localparam int NUM_REGS = NUM_LINES / FIELDS_PER_REG;
    localparam logic [REG_W-1:0] REG_RESET = {FIELDS_PER_REG{MODE_RESET}};

    logic [REG_W-1:0] regs_q [NUM_REGS];

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[r] <= REG_RESET;
            end else if (wr_en && (32'(addr) == r)) begin
                regs_q[r] <= wdata;
            end
        end
        assign mode_vec[r*REG_W +: REG_W] = regs_q[r];
    end

    always_comb begin
        rdata = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (32'(addr) == r) begin
                rdata = regs_q[r];
            end
        end
    end

endmodule

// File: rtl/xtrig_line.sv
module xtrig_line
    import xtrig_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_in,
    input  logic [MODE_W-1:0] mode,
    output logic              set_pulse
);

    line_state_e state_q;
    line_state_e state_d;
    trig_mode_e  mode_e;

    assign mode_e = trig_mode_e'(mode);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LINE_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: RISE, FALL, HOLD. Tracking runs in every mode.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_QUIET:  if (sync_in)  state_d = LINE_ACTIVE;
            LINE_ACTIVE: if (!sync_in) state_d = LINE_QUIET;
            default:     state_d = LINE_QUIET;
        endcase
    end

    // Output: both edge modes flag any change, both level modes follow the line.
    always_comb begin
        set_pulse = 1'b0;
        unique case (mode_e)
            MODE_EDGE_FALL,
            MODE_EDGE_RISE: set_pulse = (sync_in != (state_q == LINE_ACTIVE));
            MODE_LVL_LO,
            MODE_LVL_HI:    set_pulse = sync_in;
            default:        set_pulse = 1'b0;
        endcase
    end

endmodule

// File: rtl/xtrig_detect.sv
module xtrig_detect
    import xtrig_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int NUM_REGS = NUM_LINES / FIELDS_PER_REG,
    localparam int ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_in,
    input  logic                 reg_wr_en,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    output logic [NUM_LINES-1:0] req_set
);

    logic [NUM_LINES-1:0]        line_sync;
    logic [NUM_LINES*MODE_W-1:0] mode_vec;

    xtrig_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (line_in),
        .sync_out (line_sync)
    );

    xtrig_cfg #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .mode_vec (mode_vec)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        xtrig_line u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .sync_in   (line_sync[i]),
            .mode      (mode_vec[i*MODE_W +: MODE_W]),
            .set_pulse (req_set[i])
        );
    end

endmodule

// File: rtl/xtrig_detect_chk.sv
module xtrig_detect_chk #(
    parameter int NUM_LINES = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_LINES-1:0]   line_in,
    input logic                   reg_wr_en,
    input logic [NUM_LINES*2-1:0] mode_vec,
    input logic [NUM_LINES-1:0]   req_set
);

    logic [2:0] cyc_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cyc_q <= '0;
        else if (cyc_q != 7) cyc_q <= cyc_q + 3'd1;
    end

    // R1
    first_cycle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 0) |-> (req_set == '0));

    // R7
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr_en |=> $stable(mode_vec));

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
        // R3
        edge_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cyc_q >= 4 && mode_vec[2*i+1])
            |-> (req_set[i] == ($past(line_in[i], 2) != $past(line_in[i], 3))));

        // R4
        level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cyc_q >= 4 && !mode_vec[2*i+1])
            |-> (req_set[i] == $past(line_in[i], 2)));
    end

endmodule

bind xtrig_detect xtrig_detect_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_in   (line_in),
    .reg_wr_en (reg_wr_en),
    .mode_vec  (mode_vec),
    .req_set   (req_set)
);

// File: tb/sim_xtrig_detect.sv
module sim_xtrig_detect;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] line_in = '0;
    logic       reg_wr_en = 1'b0;
    logic [0:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] req_set;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #10 clk = ~clk;

    xtrig_detect u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (line_in),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .req_set   (req_set)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #5;
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #2 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        #5;
    endtask

    // Drive line b to v; expect a single one-clock strobe after two edges.
    task automatic edge_expect(input int b, input logic v, input string tag);
        @(negedge clk); line_in[b] = v;
        @(posedge clk);
        #5 chk(req_set == 8'h00, {tag, " R5 not yet"}, req_set, 8'h00);
        @(posedge clk);
        #5 chk(req_set == (8'h1 << b), {tag, " R5 strobe"}, req_set, 8'h1 << b);
        @(posedge clk);
        #5 chk(req_set == 8'h00, {tag, " R3 one clock"}, req_set, 8'h00);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        #5 chk(req_set == 8'h00, "R1 req_set in reset", req_set, 8'h00);
        rd(1'b0, d); chk(d == 8'hAA, "R1 offset0 reset", d, 8'hAA);
        rd(1'b1, d); chk(d == 8'hAA, "R1 offset1 reset", d, 8'hAA);
    endtask

    task automatic t_regs;
        logic [7:0] d;
        wr(1'b0, 8'h1B);
        rd(1'b0, d); chk(d == 8'h1B, "R2 offset0 readback", d, 8'h1B);
        rd(1'b1, d); chk(d == 8'hAA, "R7 offset1 untouched", d, 8'hAA);
        wr(1'b1, 8'hE4);
        rd(1'b1, d); chk(d == 8'hE4, "R2 offset1 readback", d, 8'hE4);
        rd(1'b0, d); chk(d == 8'h1B, "R7 offset0 untouched", d, 8'h1B);
        wr(1'b0, 8'hAA);
        wr(1'b1, 8'hAA);
    endtask

    task automatic t_edge;
        edge_expect(0, 1'b1, "R3 fall-mode rise");
        edge_expect(0, 1'b0, "R3 fall-mode fall");
        wr(1'b0, 8'hAB);        // line0 rising-edge mode
        edge_expect(0, 1'b1, "R3 rise-mode rise");
        edge_expect(0, 1'b0, "R3 rise-mode fall");
        idle(3); chk(req_set == 8'h00, "R3 stable line quiet", req_set, 8'h00);
        wr(1'b0, 8'hAA);
    endtask

    task automatic t_level(input logic [7:0] cfg, input string tag);
        wr(1'b0, cfg);
        @(negedge clk); line_in[0] = 1'b1;
        idle(2);
        for (int k = 0; k < 3; k++) begin
            chk(req_set == 8'h01, {tag, " R4 held high"}, req_set, 8'h01);
            idle(1);
        end
        @(negedge clk); line_in[0] = 1'b0;
        idle(2);
        chk(req_set == 8'h00, {tag, " R4 low clears"}, req_set, 8'h00);
        idle(2);
        chk(req_set == 8'h00, {tag, " R4 stays low"}, req_set, 8'h00);
    endtask

    task automatic t_modechange;
        wr(1'b0, 8'hA8);        // line0 low-level
        @(negedge clk); line_in[0] = 1'b1;
        idle(3);
        chk(req_set == 8'h01, "R6 level strobe before switch", req_set, 8'h01);
        wr(1'b0, 8'hAA);        // back to falling-edge, line still high
        chk(req_set == 8'h00, "R6 no strobe at switch", req_set, 8'h00);
        idle(3);
        chk(req_set == 8'h00, "R6 still quiet", req_set, 8'h00);
        edge_expect(0, 1'b0, "R6 real edge after switch");
    endtask

    task automatic t_indep;
        logic [7:0] d;
        edge_expect(5, 1'b1, "R8 line5 rise");
        wr(1'b1, 8'hA2);        // line5 low-level
        idle(1);
        chk(req_set == 8'h20, "R8 line5 level only", req_set, 8'h20);
        rd(1'b0, d); chk(d == 8'hAA, "R7 offset0 after offset1 write", d, 8'hAA);
        @(negedge clk); line_in[6] = 1'b1;
        idle(2);
        chk(req_set == 8'h60, "R8 line6 edge plus line5 level", req_set, 8'h60);
        idle(1);
        chk(req_set == 8'h20, "R8 line6 strobe ends", req_set, 8'h20);
    endtask

    initial begin
        t_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        chk(req_set == 8'h00, "R1 req_set after reset", req_set, 8'h00);
        t_regs();
        t_edge();
        t_level(8'hA8, "low-level");
        t_level(8'hA9, "high-level");
        wr(1'b0, 8'hAA);
        t_modechange();
        t_indep();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule